// File: doc/BRIEF.md
# Flit Stream Reassembler

The block takes one 32-bit flit per clock from a simplified network on which packets of many messages arrive interleaved, while the packets of any single message keep their order. Each packet opens with three key flits (source, destination, port) and a control flit whose low bit says whether this packet ends its message. One or more payload flits follow, and a flit flagged as end-of-packet closes the packet. The three keys are looked up in a small content-addressable table. A message seen for the first time gets the lowest-numbered unused page of a paged buffer. Later packets with the same keys find the stored entry and append to the same page.

Payload flits leave the block as write commands (page, offset, data) for an external page buffer. Each page keeps its own write offset, which carries over from one packet of a message to the next. When a packet that ends its message finishes, the block queues a descriptor holding the page number and the flit count in a small output FIFO. The table entry is then retired. The page stays marked used, because releasing it is the job of the downstream consumer. If a new message needs a page and none is free, the input is held off with `in_ready` and no data is lost. The input is also held off when the descriptor FIFO is full.

Top module: `flit_reassembler`

## Requirements
- R1: After reset, `in_ready` is 1, `desc_valid` is 0, `wr_en` is 0, every table entry is empty and every page is unused.
- R2: Within a packet, accepted flits 1, 2 and 3 are the source, destination and port keys. Accepted flit 4 is the control flit, and its bit 0 set means end-of-data. Every later accepted flit with `in_eop`=0 is payload and raises `wr_en` in its own cycle with `wr_data` equal to the flit. The flit with `in_eop`=1 ends the packet and is not written. `in_eop` has no effect during the first four flits.
- R3: A packet whose three keys match no valid entry is given the lowest-numbered unused page, and its first payload flit is written at offset 0.
- R4: A packet whose three keys all equal a valid entry writes to that entry's page, starting at the offset where the previous packet of the message stopped. Offsets rise by one per written flit.
- R5: Keys that differ from a stored entry in any single field, including the port alone, count as a new message and get a new page.
- R6: When the end-of-packet flit of a packet with end-of-data set is accepted, a descriptor with that page and the total number of flits written to the page is queued. The entry is retired, so a later packet with the same keys gets a new page. The old page stays used.
- R7: The end of a packet with end-of-data clear queues no descriptor.
- R8: When the keys miss and no page is unused, `in_ready` stays 0 on the control flit. Packets whose keys hit are still accepted.
- R9: When the descriptor FIFO (depth 4) is full, `in_ready` is 0 on an end-of-packet flit that must queue a descriptor. It rises in the same cycle in which `desc_ready` pops an entry, and the push and the pop then both take place.
- R10: A page holds at most 2040 flits. Payload flits beyond that are accepted with `wr_en` 0, and the reported length saturates at 2040.
- R11: Descriptors leave in the order they were queued. `desc_valid` is 1 exactly while the FIFO holds an entry, and `desc_ready` pops one entry per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input flit valid |
| in_ready | output | 1 | Block can take the flit this cycle |
| in_flit | input | 32 | Flit payload |
| in_eop | input | 1 | Marks the end-of-packet flit |
| wr_en | output | 1 | Page buffer write strobe |
| wr_page | output | 6 | Page being written |
| wr_offset | output | 11 | Flit offset within the page |
| wr_data | output | 32 | Flit to store |
| desc_valid | output | 1 | Descriptor FIFO not empty |
| desc_ready | input | 1 | Pop the head descriptor |
| desc_page | output | 6 | Head descriptor page |
| desc_len | output | 11 | Head descriptor length in flits |

## Verification
The descriptor push at the end of a finished message and a downstream pop can land in the same cycle while the FIFO is full. The bench fills the FIFO with four completed messages and holds a fifth message's end-of-packet flit until `in_ready` has stayed low for several cycles. It then raises `desc_ready`, checks that `in_ready` rises in that same cycle, and afterwards drains the FIFO. The drain must show the old head gone and the remaining four descriptors in order with their correct pages and lengths.

// File: rtl/flit_rsm_pkg.sv
package flit_rsm_pkg;
   typedef enum logic [2:0] {
      ST_KEY_SRC  = 3'd0,
      ST_KEY_DST  = 3'd1,
      ST_KEY_PORT = 3'd2,
      ST_CTRL     = 3'd3,
      ST_BODY     = 3'd4
   } rsm_state_e;

   localparam int CTRL_LAST_BIT = 0;
endpackage

// File: rtl/rsm_key_cam.sv
module rsm_key_cam #(
   parameter int ENTRIES = 64,
   parameter int KEY_W   = 32,
   parameter int IDX_W   = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [KEY_W-1:0] key_src,
   input  logic [KEY_W-1:0] key_dst,
   input  logic [KEY_W-1:0] key_port,
   input  logic             ins_en,
   input  logic [IDX_W-1:0] ins_idx,
   input  logic             del_en,
   input  logic [IDX_W-1:0] del_idx,
   output logic             hit,
   output logic [IDX_W-1:0] hit_idx
);
   logic [KEY_W-1:0] src_q  [ENTRIES];
   logic [KEY_W-1:0] dst_q  [ENTRIES];
   logic [KEY_W-1:0] port_q [ENTRIES];
   logic [ENTRIES-1:0] vld_q;
   logic [ENTRIES-1:0] src_m, dst_m, port_m, match;

   initial begin
      assert (ENTRIES >= 2 && ENTRIES <= (1 << IDX_W)) else $error("rsm_key_cam: bad ENTRIES");
   end

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      assign src_m[e]  = (src_q[e]  == key_src);
      assign dst_m[e]  = (dst_q[e]  == key_dst);
      assign port_m[e] = (port_q[e] == key_port);
      assign match[e]  = vld_q[e] & src_m[e] & dst_m[e] & port_m[e];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q[e]  <= 1'b0;
            src_q[e]  <= '0;
            dst_q[e]  <= '0;
            port_q[e] <= '0;
         end else if (ins_en && ins_idx == IDX_W'(e)) begin
            vld_q[e]  <= 1'b1;
            src_q[e]  <= key_src;
            dst_q[e]  <= key_dst;
            port_q[e] <= key_port;
         end else if (del_en && del_idx == IDX_W'(e)) begin
            vld_q[e]  <= 1'b0;
         end
      end
   end

   always_comb begin
      hit     = |match;
      hit_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match[i]) hit_idx = IDX_W'(i);
      end
   end

   AST_CAM_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match)); // R4
   AST_INS_IS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      ins_en |-> !hit); // R5
endmodule

// File: rtl/rsm_page_pool.sv
module rsm_page_pool #(
   parameter int PAGES = 64,
   parameter int CAP   = 2040,
   parameter int IDX_W = $clog2(PAGES),
   parameter int OFF_W = $clog2(CAP + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_en,
   input  logic             step_en,
   input  logic [IDX_W-1:0] sel_page,
   output logic             any_free,
   output logic [IDX_W-1:0] free_idx,
   output logic [OFF_W-1:0] sel_off,
   output logic             sel_room
);
   logic [PAGES-1:0] used_q;
   logic [OFF_W-1:0] off_q [PAGES];

   initial begin
      assert (CAP >= 1) else $error("rsm_page_pool: CAP must be positive");
      assert (PAGES <= (1 << IDX_W)) else $error("rsm_page_pool: IDX_W too narrow");
   end

   always_comb begin
      any_free = ~&used_q;
      free_idx = '0;
      for (int i = PAGES - 1; i >= 0; i--) begin
         if (!used_q[i]) free_idx = IDX_W'(i);
      end
   end

   assign sel_off  = off_q[sel_page];
   assign sel_room = (sel_off < OFF_W'(CAP));

   for (genvar p = 0; p < PAGES; p++) begin : g_page
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            used_q[p] <= 1'b0;
            off_q[p]  <= '0;
         end else if (alloc_en && free_idx == IDX_W'(p)) begin
            used_q[p] <= 1'b1;
            off_q[p]  <= '0;
         end else if (step_en && sel_room && sel_page == IDX_W'(p)) begin
            off_q[p]  <= off_q[p] + OFF_W'(1);
         end
      end
   end

   AST_ALLOC_HAS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |-> any_free); // R8
   AST_ALLOC_MARKS_USED: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |=> used_q[$past(free_idx)]); // R3
   AST_OFF_WITHIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      sel_off <= OFF_W'(CAP)); // R10
endmodule

// File: rtl/rsm_desc_fifo.sv
module rsm_desc_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 17,
   parameter int PTR_W = $clog2(DEPTH)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   logic [W-1:0]   mem_q [DEPTH];
   logic [PTR_W-1:0] wp_q, rp_q;
   logic [PTR_W:0]   cnt_q;

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0) else $error("rsm_desc_fifo: DEPTH must be a power of two");
   end

   assign full  = (cnt_q == (PTR_W + 1)'(DEPTH));
   assign empty = (cnt_q == '0);
   assign dout  = mem_q[rp_q];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wp_q <= wp_q + PTR_W'(1);
         if (pop)  rp_q <= rp_q + PTR_W'(1);
         if (push && !pop) cnt_q <= cnt_q + (PTR_W + 1)'(1);
         else if (pop && !push) cnt_q <= cnt_q - (PTR_W + 1)'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem_q[wp_q] <= din;
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full) |-> pop); // R9
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty); // R11
endmodule

// File: rtl/flit_reassembler.sv
module flit_reassembler #(
   parameter int FLIT_W     = 32,
   parameter int PAGES      = 64,
   parameter int PAGE_FLITS = 2040,
   parameter int DESC_DEPTH = 4,
   parameter int PAGE_W     = $clog2(PAGES),
   parameter int OFF_W      = $clog2(PAGE_FLITS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [FLIT_W-1:0] in_flit,
   input  logic              in_eop,
   output logic              wr_en,
   output logic [PAGE_W-1:0] wr_page,
   output logic [OFF_W-1:0]  wr_offset,
   output logic [FLIT_W-1:0] wr_data,
   output logic              desc_valid,
   input  logic              desc_ready,
   output logic [PAGE_W-1:0] desc_page,
   output logic [OFF_W-1:0]  desc_len
);
   import flit_rsm_pkg::*;

   localparam int DESC_W = PAGE_W + OFF_W;

   initial begin
      assert (FLIT_W > flit_rsm_pkg::CTRL_LAST_BIT) else $error("flit_reassembler: FLIT_W too small");
   end

   rsm_state_e        state_q;
   logic [FLIT_W-1:0] src_q, dst_q, port_q;
   logic [PAGE_W-1:0] page_q;
   logic              last_q;

   logic              cam_hit;
   logic [PAGE_W-1:0] cam_idx;
   logic              any_free;
   logic [PAGE_W-1:0] free_idx;
   logic [OFF_W-1:0]  cur_off;
   logic              room;
   logic              fifo_full, fifo_empty;
   logic [DESC_W-1:0] fifo_dout;

   logic accept, alloc_en, step_en, push, pop, body_eop;

   assign pop      = desc_ready && !fifo_empty;
   assign body_eop = (state_q == ST_BODY) && in_eop;

   always_comb begin
      unique case (state_q)
         ST_CTRL: in_ready = cam_hit || any_free;
         ST_BODY: in_ready = !(in_eop && last_q) || !fifo_full || pop;
         default: in_ready = 1'b1;
      endcase
   end

   assign accept   = in_valid && in_ready;
   assign alloc_en = accept && (state_q == ST_CTRL) && !cam_hit;
   assign step_en  = accept && (state_q == ST_BODY) && !in_eop;
   assign push     = accept && body_eop && last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_KEY_SRC;
         src_q   <= '0;
         dst_q   <= '0;
         port_q  <= '0;
         page_q  <= '0;
         last_q  <= 1'b0;
      end else if (accept) begin
         unique case (state_q)
            ST_KEY_SRC: begin
               src_q   <= in_flit;
               state_q <= ST_KEY_DST;
            end
            ST_KEY_DST: begin
               dst_q   <= in_flit;
               state_q <= ST_KEY_PORT;
            end
            ST_KEY_PORT: begin
               port_q  <= in_flit;
               state_q <= ST_CTRL;
            end
            ST_CTRL: begin
               page_q  <= cam_hit ? cam_idx : free_idx;
               last_q  <= in_flit[CTRL_LAST_BIT];
               state_q <= ST_BODY;
            end
            default: begin
               if (in_eop) state_q <= ST_KEY_SRC;
            end
         endcase
      end
   end

   rsm_key_cam #(
      .ENTRIES (PAGES),
      .KEY_W   (FLIT_W),
      .IDX_W   (PAGE_W)
   ) u_cam (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_src  (src_q),
      .key_dst  (dst_q),
      .key_port (port_q),
      .ins_en   (alloc_en),
      .ins_idx  (free_idx),
      .del_en   (push),
      .del_idx  (page_q),
      .hit      (cam_hit),
      .hit_idx  (cam_idx)
   );

   rsm_page_pool #(
      .PAGES (PAGES),
      .CAP   (PAGE_FLITS),
      .IDX_W (PAGE_W),
      .OFF_W (OFF_W)
   ) u_pool (
      .clk      (clk),
      .rst_n    (rst_n),
      .alloc_en (alloc_en),
      .step_en  (step_en),
      .sel_page (page_q),
      .any_free (any_free),
      .free_idx (free_idx),
      .sel_off  (cur_off),
      .sel_room (room)
   );

   rsm_desc_fifo #(
      .DEPTH (DESC_DEPTH),
      .W     (DESC_W)
   ) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .din   ({page_q, cur_off}),
      .pop   (pop),
      .dout  (fifo_dout),
      .full  (fifo_full),
      .empty (fifo_empty)
   );

   assign wr_en      = step_en && room;
   assign wr_page    = page_q;
   assign wr_offset  = cur_off;
   assign wr_data    = in_flit;
   assign desc_valid = !fifo_empty;
   assign desc_page  = fifo_dout[DESC_W-1:OFF_W];
   assign desc_len   = fifo_dout[OFF_W-1:0];

   AST_OFF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && $past(wr_en) && wr_page == $past(wr_page)) |->
      (wr_offset - $past(wr_offset)) == OFF_W'(1)); // R4
   AST_DESC_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> desc_valid); // R6
   AST_NO_WRITE_IN_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_BODY) |-> !wr_en); // R2
endmodule

// File: tb/flit_reassembler_bench.sv
module flit_reassembler_bench;
   localparam int CLK_PERIOD = 10;
   localparam int CAP = 2040;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_flit = '0;
   logic        in_eop = 1'b0;
   logic        wr_en;
   logic [5:0]  wr_page;
   logic [10:0] wr_offset;
   logic [31:0] wr_data;
   logic        desc_valid;
   logic        desc_ready = 1'b0;
   logic [5:0]  desc_page;
   logic [10:0] desc_len;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flit_reassembler u_flit_reassembler (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_flit(in_flit), .in_eop(in_eop), .wr_en(wr_en), .wr_page(wr_page),
      .wr_offset(wr_offset), .wr_data(wr_data), .desc_valid(desc_valid),
      .desc_ready(desc_ready), .desc_page(desc_page), .desc_len(desc_len)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // start and end at a falling edge
   task automatic xfer(input logic [31:0] f, input logic eop,
                       output logic we, output logic [5:0] pg,
                       output logic [10:0] off, output logic [31:0] dat);
      in_valid = 1'b1; in_flit = f; in_eop = eop;
      #1;
      while (!in_ready) begin
         @(negedge clk); #1;
      end
      we = wr_en; pg = wr_page; off = wr_offset; dat = wr_data;
      @(negedge clk);
      in_valid = 1'b0; in_eop = 1'b0;
   endtask

   task automatic send_hdr(input int s, input int d, input int p, input bit last);
      logic we; logic [5:0] pg; logic [10:0] off; logic [31:0] dat;
      xfer(s, 1'b1, we, pg, off, dat);   // in_eop ignored in header, R2
      chk(!we, "R2 header no write", we, 0);
      xfer(d, 1'b0, we, pg, off, dat);
      xfer(p, 1'b0, we, pg, off, dat);
      xfer({31'h5A5A_0000, last}, 1'b0, we, pg, off, dat);
      chk(!we, "R2 ctrl no write", we, 0);
   endtask

   task automatic send_data(input int n, input int pg_exp, input int start, input string req);
      logic we; logic [5:0] pg; logic [10:0] off; logic [31:0] dat;
      for (int i = 0; i < n; i++) begin
         logic [31:0] f;
         f = 32'hD000_0000 | (pg_exp << 16) | (start + i);
         xfer(f, 1'b0, we, pg, off, dat);
         chk(we && pg == pg_exp && off == start + i && dat == f, req, int'(off), start + i);
      end
   endtask

   task automatic send_eop();
      logic we; logic [5:0] pg; logic [10:0] off; logic [31:0] dat;
      xfer(32'hFFFF_FFFF, 1'b1, we, pg, off, dat);
      chk(!we, "R2 eop no write", we, 0);
   endtask

   task automatic pkt(input int s, input int d, input int p, input bit last,
                      input int n, input int pg_exp, input int start, input string req);
      send_hdr(s, d, p, last);
      send_data(n, pg_exp, start, req);
      send_eop();
   endtask

   task automatic pop_desc(input int pg_exp, input int len_exp, input string req);
      #1;
      chk(desc_valid && desc_page == pg_exp && desc_len == len_exp, req,
          int'(desc_page) * 10000 + int'(desc_len), pg_exp * 10000 + len_exp);
      desc_ready = 1'b1;
      @(negedge clk);
      desc_ready = 1'b0;
   endtask

   task automatic t_reset();
      #1;
      chk(in_ready, "R1 in_ready", in_ready, 1);
      chk(!desc_valid, "R1 desc_valid", desc_valid, 0);
      chk(!wr_en, "R1 wr_en", wr_en, 0);
   endtask

   task automatic t_basic();
      pkt(1, 2, 3, 1'b1, 3, 0, 0, "R3 first page");
      pop_desc(0, 3, "R6 descriptor");
   endtask

   task automatic t_interleave();
      pkt(5, 6, 7, 1'b0, 2, 1, 0, "R3 second message");
      pkt(5, 6, 8, 1'b0, 1, 2, 0, "R5 port differs");
      pkt(5, 6, 7, 1'b0, 2, 1, 2, "R4 hit continues offset");
      #1 chk(!desc_valid, "R7 no descriptor", desc_valid, 0);
      pkt(5, 6, 7, 1'b1, 1, 1, 4, "R4 hit last packet");
      pop_desc(1, 5, "R6 accumulated length");
      pkt(1, 2, 3, 1'b0, 1, 3, 0, "R6 retired entry new page");
   endtask

   task automatic t_fifo();
      for (int k = 0; k < 4; k++) pkt(40 + k, 0, 0, 1'b1, 1, 4 + k, 0, "R9 fill");
      send_hdr(44, 0, 0, 1'b1);
      send_data(1, 8, 0, "R9 fifth data");
      in_valid = 1'b1; in_flit = 32'hFFFF_FFFF; in_eop = 1'b1;
      #1;
      for (int c = 0; c < 3; c++) begin
         chk(!in_ready, "R9 stall when full", in_ready, 0);
         @(negedge clk); #1;
      end
      desc_ready = 1'b1;
      #1;
      chk(in_ready, "R9 push with pop same cycle", in_ready, 1);
      chk(desc_page == 4, "R11 head page", desc_page, 4);
      @(negedge clk);
      in_valid = 1'b0; in_eop = 1'b0; desc_ready = 1'b0;
      for (int k = 0; k < 4; k++) pop_desc(5 + k, 1, "R11 order");
      #1 chk(!desc_valid, "R11 drained", desc_valid, 0);
   endtask

   task automatic t_sat();
      logic we; logic [5:0] pg; logic [10:0] off; logic [31:0] dat;
      send_hdr(77, 77, 77, 1'b1);
      send_data(CAP, 9, 0, "R10 fill page");
      for (int k = 0; k < 2; k++) begin
         xfer(32'h1234_0000 + k, 1'b0, we, pg, off, dat);
         chk(!we, "R10 overflow dropped", we, 0);
      end
      send_eop();
      pop_desc(9, CAP, "R10 saturated length");
   endtask

   task automatic t_exhaust();
      for (int k = 10; k < 64; k++) pkt(100 + k, 1, 1, 1'b0, 1, k, 0, "R8 fill pages");
      pkt(5, 6, 8, 1'b1, 1, 2, 1, "R8 hit accepted when full");
      pop_desc(2, 2, "R8 hit descriptor");
      begin
         logic we; logic [5:0] pg; logic [10:0] off; logic [31:0] dat;
         xfer(999, 1'b0, we, pg, off, dat);
         xfer(998, 1'b0, we, pg, off, dat);
         xfer(997, 1'b0, we, pg, off, dat);
      end
      in_valid = 1'b1; in_flit = 32'h1;
      #1;
      for (int c = 0; c < 5; c++) begin
         chk(!in_ready, "R8 miss stalls with no page", in_ready, 0);
         @(negedge clk); #1;
      end
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_interleave();
      t_fifo();
      t_sat();
      t_exhaust();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule